// File: doc/BRIEF.md
# Serial Configuration Port Programming Master

This block is the host-side sequencer for a timer device whose settings live in a small non-volatile store. The device exposes a three-wire serial port: an active-low enable, a serial clock and a data-in line. Results come back on a separate data-out line. A client raises `start_i` for one cycle with the transaction type, the target and the data byte. The block then bit-bangs the whole exchange on the serial pins, with every phase timed by counters derived from the system clock frequency.

Two transactions exist. A read sends a control byte and then clocks eight more bits in from the device. The captured byte is presented with a one-cycle valid strobe. A program transaction sends the control byte followed by the data byte. It then parks the clock low with data-in low for a long hold, and gives one final rising edge that commits the data. For example, control 0x12 with data 0x19 selects a counter multiplier of 10, one-shot mode, low power and standard trip levels.

Top module: `cfg_prog_master`

## Requirements
- R1: After reset the outputs are: serial clock high, enable high (inactive), data-in low, busy low and valid low. Before the enable falls, the serial clock has already been low for at least one system cycle.
- R2: The device takes each bit on a rising serial-clock edge. Every high phase of the serial clock inside a transaction lasts exactly HALF_CYC = CLK_HZ/(2*SCLK_HZ) system cycles.
- R3: Bits go out least significant first. The control byte is sent on rising edges 1 to 8 and, for a program transaction, the data byte on edges 9 to 16.
- R4: The control byte is {target, command}, with the command in bits 3:0 and the target in bits 7:4. The command is 0001 for a read (`prog_i`=0) and 0010 for a program (`prog_i`=1). The target is 0001 for configuration (`trim_i`=0) and 0010 for capacitor trim (`trim_i`=1).
- R5: A read gives exactly 16 rising edges. The block samples data-out at the end of the high phases of edges 9 to 16 and assembles the byte least significant bit first. The byte appears on `rd_data_o` with `rd_valid_o` high for one cycle, in the same cycle the enable returns high.
- R6: A program transaction gives exactly 17 rising edges. Before the 17th (commit) edge, data-in is low and the clock has been low for at least HOLD_CYC = (CLK_HZ/1e6)*HOLD_US system cycles. A program transaction never raises `rd_valid_o`.
- R7: `busy_o` rises in the cycle after an accepted start. It stays high for as long as the enable is low, and it falls in the same cycle the enable returns high.
- R8: A start request that arrives while busy is ignored. The transaction in progress completes with its original control and data bytes, and no further transaction follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle transaction request |
| prog_i | input | 1 | 1 = program transaction, 0 = read |
| trim_i | input | 1 | 1 = capacitor-trim target, 0 = configuration |
| data_i | input | 8 | Byte to program |
| busy_o | output | 1 | Transaction in progress |
| rd_valid_o | output | 1 | One-cycle strobe for `rd_data_o` |
| rd_data_o | output | 8 | Byte read from the device |
| sclk_o | output | 1 | Serial clock to the device |
| en_n_o | output | 1 | Active-low enable to the device |
| sdi_o | output | 1 | Serial data to the device |
| sdo_i | input | 1 | Serial data from the device |

## Verification
The bench builds the block with CLK_HZ = 50,000,000, SCLK_HZ = 5,000,000 and HOLD_US = 2. This gives a five-cycle half-period and a 100-cycle commit hold in place of the default 250 and 500,000. With these values a complete program transaction takes a few hundred cycles. All four control-byte encodings, read bytes with the MSB or LSB set, and a start request arriving in mid-hold therefore fit into one short run. The exact phase lengths can still be measured cycle by cycle.

// File: rtl/cfg_prog_pkg.sv
package cfg_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_COMMIT
    } cpm_state_e;

    localparam logic [3:0] OP_READ    = 4'b0001;
    localparam logic [3:0] OP_PROGRAM = 4'b0010;
    localparam logic [3:0] SEL_CONFIG = 4'b0001;
    localparam logic [3:0] SEL_TRIM   = 4'b0010;

    // Control byte: target in the upper nibble, operation in the lower nibble.
    function automatic logic [7:0] ctrl_byte(input logic prog, input logic trim);
        return {(trim ? SEL_TRIM : SEL_CONFIG), (prog ? OP_PROGRAM : OP_READ)};
    endfunction

    typedef struct packed {
        cpm_state_e  state;
        logic [3:0]  bit_idx;
        logic        prog;
        logic        sclk;
        logic        en_n;
        logic        busy;
        logic        valid;
    } cpm_regs_t;

endpackage

// File: rtl/cpm_timer.sv
module cpm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load) begin
            count_d = load_val;
        end else if (count_q != '0) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign done = (count_q == '0);
endmodule

// File: rtl/cpm_shifter.sv
module cpm_shifter #(
    parameter int TX_W = 16,
    parameter int RX_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_val,
    input  logic            shift,
    input  logic            capture,
    input  logic            sdo_i,
    output logic            tx_bit,
    output logic [RX_W-1:0] rx_data
);
    logic [TX_W-1:0] tx_d, tx_q;
    logic [RX_W-1:0] rx_d, rx_q;

    always_comb begin
        tx_d = tx_q;
        rx_d = rx_q;
        if (load) begin
            tx_d = load_val;
        end else if (shift) begin
            tx_d = {1'b0, tx_q[TX_W-1:1]};
        end
        if (capture) begin
            rx_d = {sdo_i, rx_q[RX_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign tx_bit  = tx_q[0];
    assign rx_data = rx_q;
endmodule

// File: rtl/cfg_prog_master.sv
module cfg_prog_master
    import cfg_prog_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int SCLK_HZ = 100_000,
    parameter int HOLD_US = 10_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       prog_i,
    input  logic       trim_i,
    input  logic [7:0] data_i,
    output logic       busy_o,
    output logic       rd_valid_o,
    output logic [7:0] rd_data_o,
    output logic       sclk_o,
    output logic       en_n_o,
    output logic       sdi_o,
    input  logic       sdo_i
);
    localparam int BYTE_W   = 8;
    localparam int NBITS    = 2 * BYTE_W;
    localparam int HALF_CYC = CLK_HZ / (2 * SCLK_HZ);
    localparam int HOLD_CYC = (CLK_HZ / 1_000_000) * HOLD_US;
    localparam int MAX_CYC  = (HOLD_CYC > HALF_CYC) ? HOLD_CYC : HALF_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
    localparam logic [3:0] LAST_BIT = 4'(NBITS - 1);
    localparam logic [3:0] RD_FIRST = 4'(BYTE_W);

    localparam cpm_regs_t REGS_RST = '{
        state:   ST_IDLE,
        bit_idx: '0,
        prog:    1'b0,
        sclk:    1'b1,
        en_n:    1'b1,
        busy:    1'b0,
        valid:   1'b0
    };

    cpm_regs_t r_d, r_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             sh_load;
    logic             sh_shift;
    logic             sh_cap;
    logic             tx_bit;
    logic [BYTE_W-1:0] rx_byte;

    cpm_timer #(.W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    cpm_shifter #(.TX_W(NBITS), .RX_W(BYTE_W)) i_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val ({data_i, ctrl_byte(prog_i, trim_i)}),
        .shift    (sh_shift),
        .capture  (sh_cap),
        .sdo_i    (sdo_i),
        .tx_bit   (tx_bit),
        .rx_data  (rx_byte)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = HALF_LD;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        sh_cap    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state   = ST_SETUP;
                    r_d.prog    = prog_i;
                    r_d.sclk    = 1'b0;
                    r_d.busy    = 1'b1;
                    r_d.bit_idx = '0;
                    tmr_load    = 1'b1;
                    sh_load     = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    r_d.state = ST_LOW;
                    r_d.en_n  = 1'b0;
                    tmr_load  = 1'b1;
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    r_d.state = ST_HIGH;
                    r_d.sclk  = 1'b1;
                    tmr_load  = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    sh_shift = 1'b1;
                    sh_cap   = !r_q.prog && (r_q.bit_idx >= RD_FIRST);
                    if (r_q.bit_idx == LAST_BIT) begin
                        if (r_q.prog) begin
                            r_d.state = ST_HOLD;
                            r_d.sclk  = 1'b0;
                            tmr_load  = 1'b1;
                            tmr_val   = HOLD_LD;
                        end else begin
                            r_d.state = ST_IDLE;
                            r_d.en_n  = 1'b1;
                            r_d.busy  = 1'b0;
                            r_d.valid = 1'b1;
                        end
                    end else begin
                        r_d.bit_idx = r_q.bit_idx + 1'b1;
                        r_d.state   = ST_LOW;
                        r_d.sclk    = 1'b0;
                        tmr_load    = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    r_d.state = ST_COMMIT;
                    r_d.sclk  = 1'b1;
                    tmr_load  = 1'b1;
                end
            end
            ST_COMMIT: begin
                if (tmr_done) begin
                    r_d.state = ST_IDLE;
                    r_d.en_n  = 1'b1;
                    r_d.busy  = 1'b0;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = r_q.busy;
    assign rd_valid_o = r_q.valid;
    assign rd_data_o  = rx_byte;
    assign sclk_o     = r_q.sclk;
    assign en_n_o     = r_q.en_n;
    assign sdi_o      = ((r_q.state == ST_LOW) || (r_q.state == ST_HIGH)) && tx_bit;

endmodule

// File: rtl/cpm_checker.sv
module cpm_checker #(
    parameter int HOLD_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic sclk_o,
    input logic en_n_o,
    input logic sdi_o,
    input logic busy_o,
    input logic rd_valid_o
);
    logic        sclk_prev;
    logic [4:0]  edges_q;
    logic [31:0] low_q;
    logic        rise;

    assign rise = sclk_o && !sclk_prev && !en_n_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b1;
            edges_q   <= '0;
            low_q     <= '0;
        end else begin
            sclk_prev <= sclk_o;
            if (en_n_o) begin
                edges_q <= '0;
            end else if (rise) begin
                edges_q <= edges_q + 1'b1;
            end
            low_q <= (!en_n_o && !sclk_o) ? low_q + 1 : '0;
        end
    end

    AST_CLK_LOW_BEFORE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_n_o) |-> (!sclk_o && $past(!sclk_o))); // R1

    AST_BUSY_WHILE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !en_n_o |-> busy_o); // R7

    AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        edges_q <= 5'd17); // R6

    AST_COMMIT_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && edges_q == 5'd16) |-> (!sdi_o && low_q >= 32'(HOLD_CYC))); // R6

    AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> ($rose(en_n_o) && !busy_o)); // R5

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o); // R5

endmodule

bind cfg_prog_master cpm_checker #(.HOLD_CYC(HOLD_CYC)) i_cpm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_o     (sclk_o),
    .en_n_o     (en_n_o),
    .sdi_o      (sdi_o),
    .busy_o     (busy_o),
    .rd_valid_o (rd_valid_o)
);

// File: tb/test_cfg_prog_master.sv
module test_cfg_prog_master;
    localparam int CLK_HZ   = 50_000_000;
    localparam int SCLK_HZ  = 5_000_000;
    localparam int HOLD_US  = 2;
    localparam int HALF_CYC = CLK_HZ / (2 * SCLK_HZ);
    localparam int HOLD_CYC = (CLK_HZ / 1_000_000) * HOLD_US;

    typedef struct packed {
        logic       prog;
        logic [7:0] ctrl;
        logic [7:0] data;
        logic [7:0] rd;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       prog_i = 1'b0;
    logic       trim_i = 1'b0;
    logic [7:0] data_i = '0;
    logic       busy_o, rd_valid_o, sclk_o, en_n_o, sdi_o;
    logic [7:0] rd_data_o;
    logic       sdo_r = 1'b0;

    int checks = 0;
    int errors = 0;
    exp_t exp_q[$];
    logic [7:0] dev_byte = '0;

    always #10 clk = ~clk;

    cfg_prog_master #(.CLK_HZ(CLK_HZ), .SCLK_HZ(SCLK_HZ), .HOLD_US(HOLD_US)) i_cfg_prog_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .prog_i(prog_i), .trim_i(trim_i),
        .data_i(data_i), .busy_o(busy_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .sclk_o(sclk_o), .en_n_o(en_n_o), .sdi_o(sdi_o), .sdo_i(sdo_r)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: observes the serial pins, models the device, pops the scoreboard.
    logic        sclk_p = 1'b1, en_p = 1'b1;
    int          edges = 0, hi = 0, low = 0, commit_low = 0;
    logic        commit_sdi = 1'b1;
    logic [15:0] got = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!en_n_o && !busy_o) chk(1'b0, "R7 busy low while enabled", 0, 1);
            if (!en_n_o && en_p) chk(!sclk_o && !sclk_p, "R1 clock low before enable", int'({sclk_p, sclk_o}), 0);
            if (!en_n_o && sclk_o && !sclk_p) begin
                if (edges < 16) got[edges] = sdi_o;
                else begin
                    commit_sdi = sdi_o;
                    commit_low = low;
                end
                edges++;
            end
            if (!en_n_o && !sclk_o && sclk_p) begin
                chk(hi == HALF_CYC, "R2 high phase length", hi, HALF_CYC);
                hi = 0;
                if (edges >= 8 && edges < 16) sdo_r = dev_byte[edges-8];
            end
            if (en_n_o && !en_p) begin
                exp_t e;
                chk(hi == HALF_CYC, "R2 last high phase length", hi, HALF_CYC);
                chk(!busy_o, "R7 busy falls with enable", int'(busy_o), 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected transaction", edges, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got[7:0] == e.ctrl, "R3 R4 control byte", int'(got[7:0]), int'(e.ctrl));
                    if (e.prog) begin
                        chk(edges == 17, "R6 program edge count", edges, 17);
                        chk(got[15:8] == e.data, "R3 data byte", int'(got[15:8]), int'(e.data));
                        chk(!commit_sdi, "R6 data-in low at commit", int'(commit_sdi), 0);
                        chk(commit_low >= HOLD_CYC, "R6 commit hold", commit_low, HOLD_CYC);
                        chk(!rd_valid_o, "R6 no valid on program", int'(rd_valid_o), 0);
                    end else begin
                        chk(edges == 16, "R5 read edge count", edges, 16);
                        chk(rd_valid_o, "R5 valid with release", int'(rd_valid_o), 1);
                        chk(rd_data_o == e.rd, "R5 read byte", int'(rd_data_o), int'(e.rd));
                    end
                end
                edges = 0;
                hi = 0;
            end
            low = (!en_n_o && !sclk_o) ? low + 1 : 0;
            if (!en_n_o && sclk_o) hi++;
            sclk_p = sclk_o;
            en_p   = en_n_o;
        end
    end

    task automatic run_txn(input logic prog, input logic trim, input logic [7:0] data,
                           input logic [7:0] rdb, input bit intrude);
        exp_t e;
        e.prog = prog;
        e.ctrl = {(trim ? 4'b0010 : 4'b0001), (prog ? 4'b0010 : 4'b0001)};
        e.data = data;
        e.rd   = rdb;
        dev_byte = rdb;
        exp_q.push_back(e);
        @(negedge clk);
        prog_i = prog; trim_i = trim; data_i = data; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R7 busy after start", int'(busy_o), 1);
        if (intrude) begin
            repeat (180) @(negedge clk);
            prog_i = ~prog; trim_i = ~trim; data_i = ~data; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        repeat (30) begin
            @(negedge clk);
            if (!en_n_o || busy_o) chk(1'b0, "R8 no follow-on transaction", int'(busy_o), 0);
        end
        chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sclk_o && en_n_o && !busy_o && !rd_valid_o && !sdi_o, "R1 reset outputs",
            int'({sclk_o, en_n_o, busy_o, rd_valid_o, sdi_o}), 5'b11000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk_o && en_n_o && !busy_o, "R1 idle outputs", int'({sclk_o, en_n_o, busy_o}), 3'b110);
        run_txn(1'b0, 1'b0, 8'h00, 8'hA5, 1'b0);   // R5 read config
        run_txn(1'b0, 1'b1, 8'h00, 8'h3C, 1'b0);   // R4 read trim
        run_txn(1'b1, 1'b0, 8'h19, 8'h00, 1'b0);   // R6 program config 0x12 0x19
        run_txn(1'b1, 1'b1, 8'hFF, 8'h00, 1'b0);   // R6 program trim
        run_txn(1'b0, 1'b0, 8'h00, 8'h80, 1'b0);   // R5 MSB only
        run_txn(1'b0, 1'b1, 8'h00, 8'h01, 1'b0);   // R5 LSB only
        run_txn(1'b1, 1'b0, 8'h01, 8'h00, 1'b1);   // R8 start during hold
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule